// File: doc/BRIEF.md
# Shared Overload Integrator

This block guards a pair of output switches against sustained overcurrent. Every clock it takes one overload flag per channel from the current comparators and feeds a saturating up/down integrator. The integrator climbs fast while an overload is present: one step when one channel is overloaded and two steps when both are. It falls slowly when no overload is present. Brief or sparse current peaks, such as the charge current of a capacitive load, therefore drain away before they can do harm. A load fault that persists fills the integrator.

When the integrator reaches its top value, the block pulls its active-low fault output low and drops the switch enable. It then holds both low for a fixed lockout of `LOCK_CYC` clocks, clears the integrator and re-enables the switches. A separate over-temperature input skips the integrator entirely. It forces the same fault at once, and the fault releases `LOCK_CYC` clocks after the temperature flag was last seen high.

At a clock near 1.5 MHz, a permanent overload on one channel trips after 255 clocks (about 170 µs), and on both channels after 128 clocks. The default lockout of 75000 clocks gives roughly 50 ms.

Top module: `surge_guard`

## Requirements
- R1: A synchronous reset drives `fault_n` and `sw_en` high, empties the integrator and cancels any lockout in progress, so the outputs stay high after reset until a new trip.
- R2: While running, a clock with exactly one overload flag set raises the integrator by 1, and a clock with both flags set raises it by 2, saturating at 2^CNT_W-1 without wrapping. From empty, a steady single overload trips on its 255th clock and a steady dual overload trips on its 128th clock.
- R3: While running, every DECAY_DIV-th consecutive clock with no overload flag lowers the integrator by 1. No other idle clock changes it.
- R4: Idle clocks at an empty integrator leave it at 0. It never underflows.
- R5: On the clock edge at which the integrator reaches its top value, `fault_n` and `sw_en` go low. They stay low for exactly LOCK_CYC clocks and then return high.
- R6: During a lockout the overload flags are ignored and the integrator holds its value.
- R7: The integrator is 0 when a lockout ends, so a new trip needs a full fill from empty.
- R8: Any running clock with an overload restarts the decay count. One overload clock in every 10 therefore climbs and trips on the 255th overload clock, and one in every 11 never trips.
- R9: A clock with `hot` high drives both outputs low after that edge, with no integration. They return high LOCK_CYC clocks after the last clock on which `hot` was high.
- R10: `sw_en` always equals `fault_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Integrator clock |
| rst | input | 1 | Synchronous reset, active high |
| ovl_flag | input | N_CH | Overload flag per channel (bit 0 channel 0, bit 1 channel 1), high = overloaded |
| hot | input | 1 | Over-temperature flag, high = too hot |
| fault_n | output | 1 | Overload fault, low while a lockout is active (registered) |
| sw_en | output | 1 | Switch enable, high = switches may drive (registered) |

## Verification
The bench builds the block with N_CH=2, CNT_W=8 and DECAY_DIV=10, so that trip counts of 255 and 128 clocks and the one-in-ten duty boundary are exercised at their real values. LOCK_CYC is set to 40, which shortens the lockout enough to run several trips, a release directly into a fresh dual-overload fill, and a reset that lands inside a lockout, all in a few thousand clocks. Each fault edge is predicted to the exact cycle from the requirements and compared in order against the observed edges.

// File: rtl/surge_pkg.sv
package surge_pkg;

  // width needed to hold values 0..n-1, never below one bit
  function automatic int cw(int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  typedef enum logic {
    MODE_RUN  = 1'b0,
    MODE_HELD = 1'b1
  } guard_mode_e;

endpackage

// File: rtl/ovl_step.sv
module ovl_step #(
  parameter int N_CH   = 2,
  parameter int STEP_W = 2
) (
  input  logic [N_CH-1:0]   flags,
  output logic [STEP_W-1:0] step
);

  // number of overloaded channels this clock
  always_comb begin
    step = '0;
    for (int i = 0; i < N_CH; i++) begin
      step = step + STEP_W'(flags[i]);
    end
  end

endmodule

// File: rtl/decay_tick.sv
module decay_tick
  import surge_pkg::*;
#(
  parameter int DECAY_DIV = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic adv,
  output logic tick
);

  localparam int PRE_W = cw(DECAY_DIV);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(DECAY_DIV - 1);

  logic [PRE_W-1:0] pre_q;

  assign tick = adv && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pre_q <= '0;
    end else if (adv) begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/sat_accum.sv
module sat_accum #(
  parameter int CNT_W  = 8,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              hold,
  input  logic [STEP_W-1:0] up,
  input  logic              dn,
  output logic [CNT_W-1:0]  acc,
  output logic [CNT_W-1:0]  acc_nxt
);

  localparam int SUM_W = CNT_W + 1;
  localparam logic [SUM_W-1:0] TOP = {1'b0, {CNT_W{1'b1}}};

  logic [SUM_W-1:0] sum;

  always_comb begin
    sum     = {1'b0, acc} + SUM_W'(up);
    acc_nxt = acc;
    if (!hold) begin
      if (up != '0) begin
        acc_nxt = (sum > TOP) ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
      end else if (dn && (acc != '0)) begin
        acc_nxt = acc - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc <= '0;
    end else begin
      acc <= acc_nxt;
    end
  end

endmodule

// File: rtl/lock_timer.sv
module lock_timer
  import surge_pkg::*;
#(
  parameter int LOCK_CYC = 75000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active,
  output logic done
);

  localparam int LK_W = cw(LOCK_CYC);
  localparam logic [LK_W-1:0] LAST = LK_W'(LOCK_CYC - 1);

  logic [LK_W-1:0] cnt_q;

  // a new start always wins over the end of a running hold
  assign done = active && !start && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt_q  <= '0;
    end else if (done) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (active) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/surge_guard.sv
module surge_guard
  import surge_pkg::*;
#(
  parameter int N_CH      = 2,
  parameter int CNT_W     = 8,
  parameter int DECAY_DIV = 10,
  parameter int LOCK_CYC  = 75000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] ovl_flag,
  input  logic            hot,
  output logic            fault_n,
  output logic            sw_en
);

  localparam int STEP_W = cw(N_CH + 1);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  logic [STEP_W-1:0] step;
  logic [CNT_W-1:0]  acc_q;
  logic [CNT_W-1:0]  acc_nxt;
  logic              lk_active;
  logic              lk_done;
  logic              tick;
  logic              running;
  logic              ovl_clk;
  logic              idle_clk;
  logic              trip;
  logic              lock_nxt;
  guard_mode_e       mode;

  assign mode     = lk_active ? MODE_HELD : MODE_RUN;
  assign running  = (mode == MODE_RUN);
  assign ovl_clk  = running && (step != '0);
  assign idle_clk = running && (step == '0);

  ovl_step #(
    .N_CH   (N_CH),
    .STEP_W (STEP_W)
  ) u_step (
    .flags (ovl_flag),
    .step  (step)
  );

  decay_tick #(
    .DECAY_DIV (DECAY_DIV)
  ) u_tick (
    .clk   (clk),
    .rst   (rst),
    .clear (ovl_clk || lk_done),
    .adv   (idle_clk),
    .tick  (tick)
  );

  sat_accum #(
    .CNT_W  (CNT_W),
    .STEP_W (STEP_W)
  ) u_acc (
    .clk     (clk),
    .rst     (rst),
    .clear   (lk_done),
    .hold    (lk_active),
    .up      (step),
    .dn      (tick),
    .acc     (acc_q),
    .acc_nxt (acc_nxt)
  );

  assign trip = running && (acc_nxt == FULL);

  lock_timer #(
    .LOCK_CYC (LOCK_CYC)
  ) u_lock (
    .clk    (clk),
    .rst    (rst),
    .start  (hot || trip),
    .active (lk_active),
    .done   (lk_done)
  );

  assign lock_nxt = hot || trip || (lk_active && !lk_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_n <= 1'b1;
      sw_en   <= 1'b1;
    end else begin
      fault_n <= !lock_nxt;
      sw_en   <= !lock_nxt;
    end
  end

endmodule

// File: rtl/surge_guard_chk.sv
module surge_guard_chk #(
  parameter int N_CH  = 2,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [N_CH-1:0]  ovl_flag,
  input logic             hot,
  input logic             fault_n,
  input logic             sw_en,
  input logic [CNT_W-1:0] acc
);

  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};

  AST_HOT_TRIPS: assert property (@(posedge clk) disable iff (rst)
    hot |=> !fault_n);  // R9

  AST_FULL_MEANS_FAULT: assert property (@(posedge clk) disable iff (rst)
    (acc == FULL) |-> !fault_n);  // R5

  AST_DECAY_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (fault_n && $past(fault_n) && (acc < $past(acc))) |->
      ((acc + 1'b1 == $past(acc)) && ($past(ovl_flag) == '0)));  // R3

  AST_FROZEN_IN_LOCK: assert property (@(posedge clk) disable iff (rst)
    (!fault_n && !$past(fault_n)) |-> $stable(acc));  // R6

  AST_DUAL_STEP: assert property (@(posedge clk) disable iff (rst)
    (fault_n && $past(fault_n) && ($countones($past(ovl_flag)) == 2)) |->
      (acc == $past(acc) + CNT_W'(2)));  // R2

  AST_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_n) |-> (acc == '0));  // R7

  AST_OUTS_AGREE: assert property (@(posedge clk) disable iff (rst)
    sw_en == fault_n);  // R10

endmodule

bind surge_guard surge_guard_chk #(
  .N_CH  (N_CH),
  .CNT_W (CNT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ovl_flag (ovl_flag),
  .hot      (hot),
  .fault_n  (fault_n),
  .sw_en    (sw_en),
  .acc      (acc_q)
);

// File: tb/tb_surge_guard.sv
`timescale 1ns/1ps
module tb_surge_guard;

  localparam int LK = 40;

  typedef struct {
    int    cyc;
    bit    val;
    string req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ovl = 2'b00;
  logic       hot = 1'b0;
  logic       fault_n;
  logic       sw_en;

  int   cyc    = 0;
  int   n_chk  = 0;
  int   n_fail = 0;
  exp_t exp_q[$];

  surge_guard #(
    .N_CH      (2),
    .CNT_W     (8),
    .DECAY_DIV (10),
    .LOCK_CYC  (LK)
  ) dut (
    .clk      (clk),
    .rst      (rst),
    .ovl_flag (ovl),
    .hot      (hot),
    .fault_n  (fault_n),
    .sw_en    (sw_en)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic expect_edge(int at, bit v, string req);
    exp_t e;
    e.cyc = at; e.val = v; e.req = req;
    exp_q.push_back(e);
  endtask

  // inputs set at a falling edge are taken by the next rising edge
  task automatic apply(logic [1:0] f, logic h, int n);
    repeat (n) begin
      @(negedge clk);
      ovl = f;
      hot = h;
    end
  endtask

  // reset, then return the index of the first edge driven by apply
  task automatic begin_case(output int s);
    @(negedge clk);
    rst = 1'b1; ovl = 2'b00; hot = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(fault_n === 1'b1, "R1", "fault_n after reset", fault_n, 1);
    check(sw_en === 1'b1, "R1", "sw_en after reset", sw_en, 1);
    s = cyc + 2;
  endtask

  // monitor: pop one expected edge for every observed fault edge
  initial begin
    logic prev;
    exp_t e;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (rst) begin
        prev = fault_n;
      end else if (fault_n !== prev) begin
        prev = fault_n;
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R5: unexpected fault_n edge actual=%0b at cycle %0d expected=no edge",
                   fault_n, cyc);
        end else begin
          e = exp_q.pop_front();
          if (e.cyc != cyc || e.val !== fault_n) begin
            n_fail++;
            $display("FAIL %s: fault_n edge actual=%0b at cycle %0d expected=%0b at cycle %0d",
                     e.req, fault_n, cyc, e.val, e.cyc);
          end
        end
        check(sw_en === fault_n, "R10", "sw_en vs fault_n at edge", sw_en, fault_n);
      end
    end
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int s;

    // R2 single channel fill from empty, R5 lockout length
    begin_case(s);
    expect_edge(s + 254, 1'b0, "R2");
    expect_edge(s + 254 + LK, 1'b1, "R5");
    apply(2'b01, 1'b0, 255);
    apply(2'b00, 1'b0, 60);

    // R2 dual fill, R6 flags ignored in lockout, R7 refill from empty
    begin_case(s);
    expect_edge(s + 127, 1'b0, "R2");
    expect_edge(s + 127 + LK, 1'b1, "R5");
    expect_edge(s + 127 + LK + 128, 1'b0, "R7");
    expect_edge(s + 127 + LK + 128 + LK, 1'b1, "R6");
    apply(2'b11, 1'b0, 128 + LK + 128);
    apply(2'b00, 1'b0, 60);

    // R3 decay: 100 up, 35 idle gives three decrements, 158 more to trip
    begin_case(s);
    expect_edge(s + 292, 1'b0, "R3");
    expect_edge(s + 292 + LK, 1'b1, "R5");
    apply(2'b01, 1'b0, 100);
    apply(2'b00, 1'b0, 35);
    apply(2'b01, 1'b0, 158);
    apply(2'b00, 1'b0, 60);

    // R4 idle at empty does not underflow
    begin_case(s);
    expect_edge(s + 50 + 254, 1'b0, "R4");
    expect_edge(s + 50 + 254 + LK, 1'b1, "R5");
    apply(2'b00, 1'b0, 50);
    apply(2'b01, 1'b0, 255);
    apply(2'b00, 1'b0, 60);

    // R8 one overload clock in ten trips on the 255th overload clock
    begin_case(s);
    expect_edge(s + 2540, 1'b0, "R8");
    expect_edge(s + 2540 + LK, 1'b1, "R8");
    for (int k = 0; k < 255; k++) begin
      apply(2'b01, 1'b0, 1);
      apply(2'b00, 1'b0, 9);
    end
    apply(2'b00, 1'b0, 60);

    // R8 one overload clock in eleven never trips
    begin_case(s);
    for (int k = 0; k < 300; k++) begin
      apply(2'b10, 1'b0, 1);
      apply(2'b00, 1'b0, 10);
    end
    @(negedge clk);
    check(fault_n === 1'b1, "R8", "fault_n after 1:11 duty", fault_n, 1);

    // R9 temperature trip, release after the last hot clock
    begin_case(s);
    expect_edge(s, 1'b0, "R9");
    expect_edge(s + 4 + LK, 1'b1, "R9");
    apply(2'b00, 1'b1, 5);
    apply(2'b00, 1'b0, 60);

    // R7 a temperature lockout also empties a part-filled integrator
    begin_case(s);
    expect_edge(s + 200, 1'b0, "R9");
    expect_edge(s + 200 + LK, 1'b1, "R9");
    expect_edge(s + 200 + LK + 255, 1'b0, "R7");
    expect_edge(s + 200 + LK + 255 + LK, 1'b1, "R5");
    apply(2'b01, 1'b0, 200);
    apply(2'b00, 1'b1, 1);
    apply(2'b01, 1'b0, 295);
    apply(2'b00, 1'b0, 60);

    // R1 reset inside a lockout cancels it
    begin_case(s);
    expect_edge(s, 1'b0, "R9");
    apply(2'b00, 1'b1, 1);
    apply(2'b00, 1'b0, 10);
    begin_case(s);
    apply(2'b00, 1'b0, 20);
    check(fault_n === 1'b1, "R1", "fault_n after reset in lockout", fault_n, 1);
    check(sw_en === 1'b1, "R1", "sw_en after reset in lockout", sw_en, 1);

    apply(2'b00, 1'b0, 5);
    check(exp_q.size() == 0, "R5", "expected edges left unseen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule